// File: doc/BRIEF.md
# Per-Pin Digital Glitch Filter

This block cleans up the digital inputs of one 32-pin port before they reach the pin interrupt logic. Each raw pin first passes through a two-flop synchronizer. A per-pin enable then decides whether that pin goes through a glitch filter or is forwarded unfiltered. A filtered pin changes its output only after its synchronized input has disagreed with the output for more than N consecutive filter ticks. N is a 5-bit width value that all pins share. Shorter pulses are absorbed and never appear downstream.

The filter tick comes from one of two sources, and the whole port uses the same one. With the source select at 0, every bus clock cycle is a tick. With the select at 1, only cycles in which an externally generated slow-tick pulse (about 1 kHz) is high count as ticks. The slow tick is generated outside this block. Software must disable every pin filter before it changes the width or the tick source.

Top module: `pin_glitch_filter`

## Requirements
- R1: While reset is asserted, every bit of `pin_out` is 0.
- R2: A pin whose `filt_en` bit is 0 is not filtered. Its output copies its raw input three rising edges after the raw input changes, so a single-cycle pulse appears at the output.
- R3: On an enabled pin, a change of the synchronized input that lasts N filter ticks or fewer never reaches `pin_out`.
- R4: On an enabled pin, a change that lasts more than N filter ticks reaches `pin_out`. In bus-clock mode, the output changes on rising edge N+3 after the raw input changes, counting the first edge that samples the new value as edge 1.
- R5: With `width` = 0 and filtering enabled, a raw pulse of a single bus cycle passes.
- R6: The tick count of a pin restarts whenever its synchronized input again equals its output. Two pulses of N ticks each, separated by a one-cycle return to the old level, are both absorbed.
- R7: With `tick_sel` = 0, every bus clock cycle is a filter tick and `slow_tick` has no effect.
- R8: With `tick_sel` = 1, only cycles with `slow_tick` high count as ticks. An enabled pin never changes on a cycle without a tick, and a pulse that covers at most N ticks is absorbed however many bus cycles it lasts.
- R9: Bit i of `filt_en` affects only pin i. For the same pulse, enabled pins absorb it while disabled pins pass it.
- R10: At the largest width, 31, a pulse of 31 bus cycles is absorbed and a pulse of 32 bus cycles passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 32 | Raw, asynchronous pin levels |
| filt_en | input | 32 | Filter enable, one bit per pin |
| tick_sel | input | 1 | Tick source: 0 = every bus cycle, 1 = slow tick |
| slow_tick | input | 1 | Single-cycle pulse from the slow low-power timebase |
| width | input | 5 | Glitch width N in filter ticks, shared by all pins |
| pin_out | output | 32 | Filtered pin levels toward interrupt logic |

## Verification
A pin counter that fails to restart, or that compares against the wrong limit, shows at the ports as a pulse that should have been absorbed but appears. It can also show as a long level whose output edge lands one or more bus cycles away from edge N+3. Either effect is visible within a few cycles after the pulse ends. A wrong tick gate shows as a filtered pin that moves on a cycle without a slow tick, or that ignores the tick source entirely. This is exposed by running the same pulse lengths in both modes. Cross-talk between pins shows on the first pulse applied with a mixed enable mask.

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter #(
  parameter int PINS = 32,
  parameter int WW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_raw,
  input  logic [PINS-1:0] filt_en,
  input  logic            tick_sel,
  input  logic            slow_tick,
  input  logic [WW-1:0]   width,
  output logic [PINS-1:0] pin_out
);

  logic [PINS-1:0] sync1, sync2, held;
  logic            tick;

  assign tick    = tick_sel ? slow_tick : 1'b1;
  assign pin_out = held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_raw;
      sync2 <= sync1;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [WW-1:0] cnt;
    logic          lvl;
    logic          diff;

    assign diff    = sync2[i] ^ lvl;
    assign held[i] = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        lvl <= 1'b0;
      end else if (!filt_en[i]) begin
        cnt <= '0;
        lvl <= sync2[i];
      end else if (!diff) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == width) begin
          cnt <= '0;
          lvl <= sync2[i];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

module pgf_checker #(
  parameter int PINS = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PINS-1:0] filt_en,
  input logic [PINS-1:0] sync_q,
  input logic [PINS-1:0] pin_out,
  input logic            tick_sel,
  input logic            slow_tick
);

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> pin_out == '0);

  for (genvar i = 0; i < PINS; i++) begin : g_chk
    a_r2_bypass_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !filt_en[i] |=> pin_out[i] == $past(sync_q[i]));

    a_r8_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_en[i] && tick_sel && !slow_tick) |=> pin_out[i] == $past(pin_out[i]));

    a_r4_moves_to_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out[i] != $past(pin_out[i])) |-> pin_out[i] == $past(sync_q[i]));
  end

endmodule

bind pin_glitch_filter pgf_checker #(.PINS(PINS)) u_pgf_chk (
  .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .sync_q(sync2),
  .pin_out(pin_out), .tick_sel(tick_sel), .slow_tick(slow_tick)
);

// File: tb/sim_pin_glitch_filter.sv
module sim_pin_glitch_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_raw = '0;
  logic [31:0] filt_en = '0;
  logic        tick_sel = 1'b0;
  logic        slow_tick = 1'b0;
  logic [4:0]  width = '0;
  logic [31:0] pin_out;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  finished = 0;
  bit  tick_run = 0;
  int  tick_cnt = 0;

  logic [31:0] seen_acc = '0;

  typedef struct {
    string       tag;
    logic [31:0] exp_seen;
  } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  pin_glitch_filter u0 (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .filt_en(filt_en),
    .tick_sel(tick_sel), .slow_tick(slow_tick), .width(width), .pin_out(pin_out)
  );

  always @(negedge clk) begin
    seen_acc  = seen_acc | pin_out;
    tick_cnt  = (tick_cnt + 1) % 4;
    slow_tick = tick_run && (tick_cnt == 3);
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      wait (exp_q.size() != 0);
      it = exp_q.pop_front();
      check({it.tag, " peak"}, seen_acc, it.exp_seen);
      check({it.tag, " settle"}, pin_out, 32'h0);
    end
  end

  task automatic configure(logic [31:0] en, logic sel, logic [4:0] w);
    filt_en = '0;
    @(negedge clk);
    tick_sel = sel;
    width = w;
    @(negedge clk);
    filt_en = en;
    @(negedge clk);
  endtask

  task automatic run_case(string tag, logic [31:0] mask, int on1, int off1, int on2,
                          logic [31:0] exp_seen);
    item_t it;
    seen_acc = '0;
    pin_raw = mask;
    repeat (on1) @(negedge clk);
    pin_raw = '0;
    repeat (off1) @(negedge clk);
    if (on2 > 0) begin
      pin_raw = mask;
      repeat (on2) @(negedge clk);
      pin_raw = '0;
    end
    repeat (80) @(negedge clk);
    it.tag = tag;
    it.exp_seen = exp_seen;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check("R1 reset", pin_out, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    configure(32'h0, 1'b0, 5'd4);
    run_case("R2 bypass 1-cycle", 32'hFFFF_FFFF, 1, 0, 0, 32'hFFFF_FFFF);

    configure(32'hFFFF_FFFF, 1'b0, 5'd0);
    run_case("R5 width0 1-cycle", 32'hA5A5_5A5A, 1, 0, 0, 32'hA5A5_5A5A);

    configure(32'hFFFF_FFFF, 1'b0, 5'd4);
    run_case("R3 N4 pulse4", 32'hFFFF_FFFF, 4, 0, 0, 32'h0);
    run_case("R4 N4 pulse5", 32'hFFFF_FFFF, 5, 0, 0, 32'hFFFF_FFFF);
    run_case("R6 N4 4+gap+4", 32'hFFFF_FFFF, 4, 1, 4, 32'h0);

    configure(32'hFFFF_FFFF, 1'b0, 5'd3);
    pin_raw = 32'h1;
    repeat (5) @(negedge clk);
    check("R4 latency edge N+2", pin_out, 32'h0);
    @(negedge clk);
    check("R4 latency edge N+3", pin_out, 32'h1);
    pin_raw = '0;
    repeat (20) @(negedge clk);
    check("R4 return low", pin_out, 32'h0);

    configure(32'h0000_FFFF, 1'b0, 5'd2);
    run_case("R9 mixed enable", 32'hFFFF_FFFF, 2, 0, 0, 32'hFFFF_0000);

    configure(32'hFFFF_FFFF, 1'b0, 5'd31);
    run_case("R10 N31 pulse31", 32'hFFFF_FFFF, 31, 0, 0, 32'h0);
    run_case("R10 N31 pulse32", 32'hFFFF_FFFF, 32, 0, 0, 32'hFFFF_FFFF);

    tick_run = 1;
    configure(32'hFFFF_FFFF, 1'b0, 5'd1);
    run_case("R7 bus mode pulse1", 32'h0F0F_0F0F, 1, 0, 0, 32'h0);
    run_case("R7 bus mode pulse2", 32'h0F0F_0F0F, 2, 0, 0, 32'h0F0F_0F0F);
    run_case("R7 bus mode pulse3", 32'h0F0F_0F0F, 3, 0, 0, 32'h0F0F_0F0F);

    configure(32'hFFFF_FFFF, 1'b1, 5'd1);
    run_case("R8 slow pulse3", 32'h0F0F_0F0F, 3, 0, 0, 32'h0);
    run_case("R8 slow pulse12", 32'h0F0F_0F0F, 12, 0, 0, 32'h0F0F_0F0F);
    tick_run = 0;
    @(negedge clk);
    run_case("R8 no tick pulse20", 32'hFFFF_FFFF, 20, 0, 0, 32'h0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule